// File: doc/BRIEF.md
# Single-Bit-Set Detector Tree

This block looks at an N-bit word and raises one flag when exactly one bit of the word is set. An unsigned value with that property is a nonzero power of two. The block does not use the subtract-and-mask idiom. It reduces the word through a balanced binary tree instead. Every node of the tree passes two signals to its parent:
- `any`: at least one bit below the node is set.
- `many`: more than one bit below the node is set.

Each node works out its pair from its two children. `any` is the OR of the children's `any`. `many` is the OR of three terms: the children's `many`, and the AND of the two children's `any`.

Unused leaves are tied to zero, so the leaf count is the next power of two at or above N. This means every input bit passes through the same number of node levels. A single final stage then forms the flag from the root's `any` and the inverse of the root's `many`.

The flag can be taken straight from the tree or from a register. The register loads on the rising clock edge and has a synchronous, active-high reset.

Top module: `pow2_flag_tree`

## Requirements
- R1: `flag` is 1 exactly when the population count of the sampled `din` equals 1, and 0 for every other value.
- R2: An all-zero `din` gives `flag` = 0.
- R3: Any `din` with two or more bits set gives `flag` = 0. This includes the pattern with bit 0 and bit 5 set (value 0x21), where the two set bits first meet above the lowest node level.
- R4: For every bit position k from 0 to WIDTH-1, `din` = 1<<k gives `flag` = 1.
- R5: With REG_OUT = 1, `flag` shows the value computed from `din` as sampled at the previous rising edge of `clk`. With REG_OUT = 0, `flag` follows `din` combinationally.
- R6: With REG_OUT = 1, a rising edge with `rst` = 1 sets `flag` to 0, whatever `din` is.
- R7: A WIDTH that is not a power of two behaves as in R1. The padding leaves never raise `flag`, and a single set top bit (bit WIDTH-1) gives 1.
- R8: `flag` equals the reference expression `(v != 0) && ((v & (v-1)) == 0)`, computed at WIDTH bits, for every tested value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| din | input | WIDTH | Word under test |
| flag | output | 1 | 1 when exactly one bit of `din` is set |

## Verification
The bench tests three configurations:
- A 12-bit direct-output instance is tried with every one of its 4096 words. This covers zero, every single-bit word and every multi-bit word, against both the population-count reference and the mask reference.
- A 7-bit registered instance is swept over all its words. This shows that the zero padding leaves stay inert and that the result arrives one edge after `din` is sampled.
- A 32-bit registered instance gets every single-bit word and every two-bit word, the 0x21 pattern, all ones and random words. The single-bit words show that each leaf reaches the root. The two-bit words show that `many` is raised wherever the two set bits meet in the tree.

Asserting reset while `din` holds a single set bit tells the reset path apart from the data path.

// File: rtl/pow2_pkg.sv
package pow2_pkg;

  typedef struct packed {
    logic any;
    logic many;
  } cnt_sum_t;

  function automatic int tree_levels(input int width);
    return (width < 2) ? 1 : $clog2(width);
  endfunction

endpackage

// File: rtl/pow2_node.sv
module pow2_node
  import pow2_pkg::*;
(
  input  cnt_sum_t lhs,
  input  cnt_sum_t rhs,
  output cnt_sum_t sum
);

  assign sum.any  = lhs.any | rhs.any;
  assign sum.many = lhs.many | rhs.many | (lhs.any & rhs.any);

endmodule

// File: rtl/pow2_tree.sv
module pow2_tree
  import pow2_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] din,
  output cnt_sum_t         root
);

  localparam int LEVELS = tree_levels(WIDTH);
  localparam int LEAVES = 1 << LEVELS;
  localparam int NODES  = 2 * LEAVES - 1;

  // Heap layout: node i has children 2i+1 and 2i+2, leaves at the tail.
  cnt_sum_t nd [NODES];

  for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
    if (j < WIDTH) begin : g_real
      assign nd[LEAVES-1+j] = '{any: din[j], many: 1'b0};
    end else begin : g_pad
      assign nd[LEAVES-1+j] = '{any: 1'b0, many: 1'b0};
    end
  end

  for (genvar i = 0; i < LEAVES - 1; i++) begin : g_node
    pow2_node u_node (
      .lhs (nd[2*i+1]),
      .rhs (nd[2*i+2]),
      .sum (nd[i])
    );
  end

  assign root = nd[0];

endmodule

// File: rtl/pow2_finish.sv
module pow2_finish
  import pow2_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic     clk,
  input  logic     rst,
  input  cnt_sum_t root,
  output logic     flag
);

  logic flag_c;

  // One stage joins both root signals so neither path is longer.
  assign flag_c = root.any & ~root.many;

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) flag <= 1'b0;
      else     flag <= flag_c;
    end
  end else begin : g_comb
    assign flag = flag_c;
  end

endmodule

// File: rtl/pow2_flag_tree.sv
module pow2_flag_tree
  import pow2_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic             flag
);

  cnt_sum_t root;

  pow2_tree #(.WIDTH(WIDTH)) u_tree (
    .din  (din),
    .root (root)
  );

  pow2_finish #(.REG_OUT(REG_OUT)) u_finish (
    .clk  (clk),
    .rst  (rst),
    .root (root),
    .flag (flag)
  );

endmodule

// File: rtl/pow2_flag_chk.sv
module pow2_flag_chk #(
  parameter int WIDTH   = 32,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] din,
  input logic             flag,
  input logic             root_any
);

  // Root "any" from the tree against a direct reduction of the port.
  p_root_any_r1: assert property (@(posedge clk) disable iff (rst)
    root_any == (|din));

  if (REG_OUT) begin : g_reg
    p_popcount_r1: assert property (@(posedge clk) disable iff (rst)
      !rst |=> (flag == ($countones($past(din)) == 1)));
    p_zero_low_r2: assert property (@(posedge clk) disable iff (rst)
      (din == '0) |=> !flag);
    p_multi_low_r3: assert property (@(posedge clk) disable iff (rst)
      ($countones(din) > 1) |=> !flag);
    p_single_high_r4: assert property (@(posedge clk) disable iff (rst)
      ($countones(din) == 1) |=> flag);
  end else begin : g_comb
    p_popcount_r1: assert property (@(posedge clk) disable iff (rst)
      flag == ($countones(din) == 1));
    p_zero_low_r2: assert property (@(posedge clk) disable iff (rst)
      (din == '0) |-> !flag);
    p_multi_low_r3: assert property (@(posedge clk) disable iff (rst)
      ($countones(din) > 1) |-> !flag);
    p_single_high_r4: assert property (@(posedge clk) disable iff (rst)
      ($countones(din) == 1) |-> flag);
  end

endmodule

bind pow2_flag_tree pow2_flag_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .din      (din),
  .flag     (flag),
  .root_any (root.any)
);

// File: tb/test_pow2_flag_tree.sv
module test_pow2_flag_tree;

  localparam int CLK_PERIOD = 10;
  localparam int W_BIG = 32;
  localparam int W_SML = 12;
  localparam int W_ODD = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W_BIG-1:0] din_big = '0;
  logic [W_SML-1:0] din_sml = '0;
  logic [W_ODD-1:0] din_odd = '0;
  logic flag_big, flag_sml, flag_odd;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pow2_flag_tree #(.WIDTH(W_BIG), .REG_OUT(1'b1)) i_pow2_flag_tree (
    .clk(clk), .rst(rst), .din(din_big), .flag(flag_big));
  pow2_flag_tree #(.WIDTH(W_SML), .REG_OUT(1'b0)) i_pow2_flag_tree_sml (
    .clk(clk), .rst(rst), .din(din_sml), .flag(flag_sml));
  pow2_flag_tree #(.WIDTH(W_ODD), .REG_OUT(1'b1)) i_pow2_flag_tree_odd (
    .clk(clk), .rst(rst), .din(din_odd), .flag(flag_odd));

  function automatic bit ref_pop(input logic [63:0] v, input int w);
    int n = 0;
    for (int k = 0; k < w; k++) if (v[k]) n++;
    return n == 1;
  endfunction

  function automatic bit ref_mask(input logic [63:0] v, input int w);
    logic [63:0] m = (64'd1 << w) - 64'd1;
    logic [63:0] x = v & m;
    return (x != 0) && (((x & (x - 64'd1)) & m) == 0);
  endfunction

  task automatic check(input string req, input logic act, input logic exp,
                       input logic [63:0] v);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s din=%h actual=%b expected=%b", req, v, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // Apply words at the falling edge; combinational result checked there,
  // registered results checked just after the next rising edge.
  task automatic apply(input logic [W_BIG-1:0] vb, input logic [W_SML-1:0] vs,
                       input logic [W_ODD-1:0] vo, input string rb,
                       input string rs, input string ro);
    @(negedge clk);
    din_big = vb; din_sml = vs; din_odd = vo;
    #1;
    check({rs, " R5 R8 comb"}, flag_sml, ref_mask(64'(vs), W_SML), 64'(vs));
    check({rs, " R1"}, flag_sml, ref_pop(64'(vs), W_SML), 64'(vs));
    @(posedge clk);
    #1;
    check({rb, " R5 reg"}, flag_big, ref_pop(64'(vb), W_BIG), 64'(vb));
    check({rb, " R8"}, flag_big, ref_mask(64'(vb), W_BIG), 64'(vb));
    check({ro, " R7"}, flag_odd, ref_pop(64'(vo), W_ODD), 64'(vo));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [W_BIG-1:0] r;
    // R6: reset clears registered flags even with a single-bit input.
    din_big = 32'h0000_0100; din_odd = 7'h04; din_sml = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R6 reset state", flag_big, 1'b0, 64'(din_big));
    check("R6 reset state", flag_odd, 1'b0, 64'(din_odd));
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #1;
    check("R5 after reset release", flag_big, 1'b1, 64'(din_big));

    // Exhaustive on the 12-bit and 7-bit instances.
    for (int v = 0; v < (1 << W_SML); v++)
      apply(W_BIG'(v), W_SML'(v), W_ODD'(v), "R1", "R1", "R7");

    // R2 zero, R3 bits 0 and 5, R7 top bit of the odd width.
    apply('0, '0, '0, "R2", "R2", "R2");
    check("R2 zero", flag_big, 1'b0, 64'd0);
    apply(32'h21, 12'h021, 7'h21, "R3", "R3", "R3");
    check("R3 bits0and5", flag_big, 1'b0, 64'h21);
    check("R3 bits0and5", flag_odd, 1'b0, 64'h21);
    apply(32'h40, 12'h800, 7'h40, "R4", "R4", "R7");
    check("R7 top bit", flag_odd, 1'b1, 64'h40);

    // R4 each single bit of the 32-bit instance.
    for (int k = 0; k < W_BIG; k++) begin
      apply(W_BIG'(1) << k, W_SML'(1) << (k % W_SML), W_ODD'(1) << (k % W_ODD),
            "R4", "R4", "R4");
      check("R4 single", flag_big, 1'b1, 64'(W_BIG'(1) << k));
    end

    // R3 every two-bit word of the 32-bit instance.
    for (int a = 0; a < W_BIG; a++)
      for (int b = a + 1; b < W_BIG; b++) begin
        apply((W_BIG'(1) << a) | (W_BIG'(1) << b), '0, '0, "R3", "R2", "R2");
        check("R3 pair", flag_big, 1'b0, 64'((W_BIG'(1) << a) | (W_BIG'(1) << b)));
      end

    apply('1, '1, '1, "R3", "R3", "R3");
    check("R3 all ones", flag_big, 1'b0, 64'hFFFF_FFFF);

    // Random words, sparse ones too.
    for (int n = 0; n < 2000; n++) begin
      r = $urandom();
      if (n % 2 == 1) r = r & $urandom() & $urandom() & $urandom();
      apply(r, r[W_SML-1:0], r[W_ODD-1:0], "R1", "R1", "R7");
    end

    // R6 synchronous reset mid-run with a single bit applied.
    @(negedge clk);
    din_big = 32'h8000_0000; din_odd = 7'h01; rst = 1'b1;
    @(posedge clk); #1;
    check("R6 sync reset", flag_big, 1'b0, 64'(din_big));
    check("R6 sync reset", flag_odd, 1'b0, 64'(din_odd));
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #1;
    check("R5 resume", flag_big, 1'b1, 64'(din_big));

    done = 1'b1;
    summary();
    $finish;
  end

endmodule